// File: doc/BRIEF.md
# Expansion ROM Bank Select Decoder

This block sits on an expansion card for an 8-bit home computer that pages one of 256 ROM banks into the top 16 KiB of the address space. The host never keeps the selected bank number. Software selects a bank by writing an I/O port, and every card that owns a ROM must watch for that write itself. This decoder watches the bus for I/O writes whose upper address byte is DFh. It compares the written byte with the card's own bank number and keeps a single flag that records whether the two matched.

While the flag is set and the CPU reads from the upper half of memory (A15 high), the decoder enables the card's ROM outputs. It also raises a disable line to the host, so that the built-in ROM stays off the bus. While the flag is clear, the decoder leaves everything to the host, and the built-in ROM answers for that bank number. The card ROM's chip-select comes straight from the host's ROM-enable strobe. A14 is not decoded, because ROM only appears in the upper window.

A compare mask lets the card ignore chosen bits of the bank number, so one ROM can answer at several mirrored bank numbers. The bus strobes are sampled into the system clock domain. A select write takes effect once its write strobe has been released.

Top module: `xrom_bank_decoder`

## Requirements
- R1: After reset the bank flag is clear: with A15 high, rom_oe_n is 1 and host_rom_dis is 0 until a matching select write completes.
- R2: A completed I/O write (iorq_n=0, wr_n=0) to an address with bits 15:8 = DFh sets the flag when (data XOR BANK_ID) AND BANK_MASK is zero. While the flag is set and A15=1, rom_oe_n is 0 and host_rom_dis is 1.
- R3: A completed select write whose masked data differs from the masked BANK_ID clears the flag. While the flag is clear, rom_oe_n is 1 and host_rom_dis is 0 at every address.
- R4: Address bits 7:0 of the select write are ignored. Cycles that do not change the flag are: I/O writes with bits 15:8 other than DFh, I/O reads (wr_n=1) of the select port, and memory writes (iorq_n=1).
- R5: With A15=0, rom_oe_n is 1 and host_rom_dis is 0 whatever the flag holds.
- R6: A14 is not decoded: addresses 8000h and C000h produce identical outputs.
- R7: rom_cs_n equals hrom_en_n at all times, with no clock delay.
- R8: Bits that are 0 in BANK_MASK are not compared. With BANK_ID=06h and BANK_MASK=0Fh, the ROM answers at 06h, 16h, 26h and so on up to F6h, and at no other number.
- R9: The flag keeps its old value while the write strobe is still low. The new value is in force no later than three clock edges after the strobe rises.
- R10: When the data bus changes during a select write, the byte present at the last clock edge before the strobe ends is the one compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset; clears the bank flag |
| addr | input | 16 | CPU address bus |
| data | input | 8 | CPU data bus |
| iorq_n | input | 1 | Active-low I/O request strobe |
| wr_n | input | 1 | Active-low write strobe |
| hrom_en_n | input | 1 | Host active-low ROM-enable strobe |
| rom_oe_n | output | 1 | Active-low output enable to the card ROM |
| rom_cs_n | output | 1 | Active-low chip select to the card ROM |
| host_rom_dis | output | 1 | Active-high request to the host to disable its built-in ROM |

## Verification
The hardest situation to reach from the ports is a select write whose data changes while the strobe is still low. Only the last sampled byte may decide the flag, and the flag must not move before the strobe rises. The bench holds the strobe low across several clock edges and swaps the data byte partway through. It also samples the outputs mid-strobe, where the address DFxxh already has A15 high, so an early flag update would show on host_rom_dis. Two instances, one fully compared and one with a 0Fh mask, are driven together through all 256 bank numbers, with reads made in each quarter of the address space.

// File: rtl/xrom_pkg.sv
package xrom_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // True when the upper address byte selects the bank port.
  function automatic logic port_hit(input byte_t addr_hi, input byte_t port_id);
    return addr_hi == port_id;
  endfunction

  // True when the card should own the upper window for this access.
  function automatic logic window_owned(input logic flag, input logic a_top);
    return flag & a_top;
  endfunction
endpackage

// File: rtl/xrom_port_snoop.sv
module xrom_port_snoop
  import xrom_pkg::*;
#(
  parameter byte_t PORT_HI = 8'hDF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t addr_hi,
  input  byte_t data,
  input  logic  iorq_n,
  input  logic  wr_n,
  output byte_t cap_byte,
  output logic  cap_done
);
  logic  io_wr_now;
  logic  act_q, act_q2;
  byte_t data_q, held_q;

  assign io_wr_now = ~iorq_n & ~wr_n & port_hit(addr_hi, PORT_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      act_q2 <= 1'b0;
      data_q <= '0;
      held_q <= '0;
    end else begin
      act_q  <= io_wr_now;
      act_q2 <= act_q;
      data_q <= data;
      if (act_q) held_q <= data_q;
    end
  end

  // Strobe end seen in the clock domain: one cycle pulse.
  assign cap_done = act_q2 & ~act_q;
  assign cap_byte = held_q;
endmodule

// File: rtl/xrom_match_flag.sv
module xrom_match_flag
  import xrom_pkg::*;
#(
  parameter byte_t BANK_ID   = 8'h07,
  parameter byte_t BANK_MASK = 8'hFF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t cap_byte,
  input  logic  cap_done,
  output logic  match,
  output logic  flag
);
  logic [BYTE_W-1:0] bit_ok;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    if (BANK_MASK[i]) begin : g_cmp
      assign bit_ok[i] = (cap_byte[i] == BANK_ID[i]);
    end else begin : g_free
      assign bit_ok[i] = 1'b1;
    end
  end

  assign match = &bit_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (cap_done) flag <= match;
  end
endmodule

// File: rtl/xrom_window_drive.sv
module xrom_window_drive
  import xrom_pkg::*;
(
  input  logic flag,
  input  logic a_top,
  input  logic hrom_en_n,
  output logic rom_oe_n,
  output logic rom_cs_n,
  output logic host_rom_dis
);
  logic owned;

  assign owned        = window_owned(flag, a_top);
  assign rom_oe_n     = ~owned;
  assign host_rom_dis = owned;
  assign rom_cs_n     = hrom_en_n;
endmodule

// File: rtl/xrom_bank_decoder.sv
module xrom_bank_decoder
  import xrom_pkg::*;
#(
  parameter int    ADDR_W    = 16,
  parameter byte_t PORT_HI   = 8'hDF,
  parameter byte_t BANK_ID   = 8'h07,
  parameter byte_t BANK_MASK = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              iorq_n,
  input  logic              wr_n,
  input  logic              hrom_en_n,
  output logic              rom_oe_n,
  output logic              rom_cs_n,
  output logic              host_rom_dis
);
  localparam int LO_W = ADDR_W - BYTE_W;

  byte_t addr_hi;
  logic  a_top;
  logic  unused_addr_lo;
  byte_t snoop_byte;
  logic  snoop_done;
  logic  bank_match;
  logic  bank_flag;

  assign addr_hi        = addr[ADDR_W-1 -: BYTE_W];
  assign a_top          = addr[ADDR_W-1];
  assign unused_addr_lo = ^addr[LO_W-1:0];

  xrom_port_snoop #(.PORT_HI(PORT_HI)) u_snoop (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_hi  (addr_hi),
    .data     (data),
    .iorq_n   (iorq_n),
    .wr_n     (wr_n),
    .cap_byte (snoop_byte),
    .cap_done (snoop_done)
  );

  xrom_match_flag #(.BANK_ID(BANK_ID), .BANK_MASK(BANK_MASK)) u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_byte (snoop_byte),
    .cap_done (snoop_done),
    .match    (bank_match),
    .flag     (bank_flag)
  );

  xrom_window_drive u_drive (
    .flag         (bank_flag),
    .a_top        (a_top),
    .hrom_en_n    (hrom_en_n),
    .rom_oe_n     (rom_oe_n),
    .rom_cs_n     (rom_cs_n),
    .host_rom_dis (host_rom_dis)
  );
endmodule

// File: rtl/xrom_bank_decoder_chk.sv
module xrom_bank_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic a_top,
  input logic hrom_en_n,
  input logic rom_oe_n,
  input logic rom_cs_n,
  input logic host_rom_dis,
  input logic cap_done,
  input logic match,
  input logic flag
);
  p_cs_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs_n == hrom_en_n);

  p_low_half_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !a_top |-> (rom_oe_n && !host_rom_dis));

  p_take_over_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && a_top) |-> (!rom_oe_n && host_rom_dis));

  p_host_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> (rom_oe_n && !host_rom_dis));

  p_set_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && match) |=> flag);

  p_clear_on_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && !match) |=> !flag);

  p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_done |=> $stable(flag));
endmodule

bind xrom_bank_decoder xrom_bank_decoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .a_top        (a_top),
  .hrom_en_n    (hrom_en_n),
  .rom_oe_n     (rom_oe_n),
  .rom_cs_n     (rom_cs_n),
  .host_rom_dis (host_rom_dis),
  .cap_done     (snoop_done),
  .match        (bank_match),
  .flag         (bank_flag)
);

// File: tb/xrom_bank_decoder_bench.sv
module xrom_bank_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ID_A = 8'h07, MASK_A = 8'hFF;
  localparam logic [7:0] ID_B = 8'h06, MASK_B = 8'h0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data = 8'h00;
  logic iorq_n = 1'b1, wr_n = 1'b1, hrom_en_n = 1'b1;
  logic oe_a, cs_a, dis_a, oe_b, cs_b, dis_b;
  logic exp_a = 1'b0, exp_b = 1'b0;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xrom_bank_decoder #(.BANK_ID(ID_A), .BANK_MASK(MASK_A)) u_xrom_bank_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .iorq_n(iorq_n),
    .wr_n(wr_n), .hrom_en_n(hrom_en_n), .rom_oe_n(oe_a), .rom_cs_n(cs_a),
    .host_rom_dis(dis_a));

  xrom_bank_decoder #(.BANK_ID(ID_B), .BANK_MASK(MASK_B)) u_xrom_bank_decoder_m (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .iorq_n(iorq_n),
    .wr_n(wr_n), .hrom_en_n(hrom_en_n), .rom_oe_n(oe_b), .rom_cs_n(cs_b),
    .host_rom_dis(dis_b));

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b (addr %h)", req, act, exp, addr);
    end
  endtask

  function automatic logic hits(input logic [7:0] v, input logic [7:0] id,
                                input logic [7:0] m);
    return ((v ^ id) & m) == 8'h00;
  endfunction

  // Read at one address and check both instances against the model.
  task automatic read_at(input logic [15:0] a, input logic en_n, input string req);
    @(negedge clk);
    addr = a; iorq_n = 1'b1; wr_n = 1'b1; hrom_en_n = en_n;
    #(CLK_PERIOD/4);
    chk(req, dis_a, exp_a & a[15]);
    chk(req, oe_a, ~(exp_a & a[15]));
    chk(req, dis_b, exp_b & a[15]);
    chk(req, oe_b, ~(exp_b & a[15]));
    chk("R7", cs_a, en_n);
    chk("R7", cs_b, en_n);
  endtask

  task automatic read_four(input string req);
    read_at(16'hC000, 1'b0, req);
    read_at(16'h8123, 1'b1, "R6");
    read_at(16'h4000, 1'b0, "R5");
    read_at(16'h00FF, 1'b1, "R5");
  endtask

  // Bus cycle: strobes low for several edges, then release.
  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d0,
                           input logic [7:0] d1, input logic io_n,
                           input logic w_n, input logic counts);
    @(negedge clk);
    addr = a; data = d0; iorq_n = io_n; wr_n = w_n;
    repeat (2) @(negedge clk);
    data = d1;
    repeat (2) @(negedge clk);
    #(CLK_PERIOD/4);
    // R9: flag must still hold the previous value while the strobe is low.
    chk("R9", dis_a, exp_a & a[15]);
    chk("R9", dis_b, exp_b & a[15]);
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(negedge clk);
    if (counts) begin
      exp_a = hits(d1, ID_A, MASK_A);
      exp_b = hits(d1, ID_B, MASK_B);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    chk("R1", oe_a, 1'b1); chk("R1", dis_a, 1'b0);
    rst_n = 1'b1;
    addr = 16'hC000;
    #(CLK_PERIOD/4);
    chk("R1", oe_a, 1'b1); chk("R1", dis_a, 1'b0);
    chk("R1", oe_b, 1'b1); chk("R1", dis_b, 1'b0);
    read_four("R1");

    // Match, miss, match again.
    bus_cycle(16'hDF00, ID_A, ID_A, 1'b0, 1'b0, 1'b1); read_four("R2");
    bus_cycle(16'hDF42, 8'h08, 8'h08, 1'b0, 1'b0, 1'b1); read_four("R3");
    bus_cycle(16'hDFFF, ID_A, ID_A, 1'b0, 1'b0, 1'b1); read_four("R2");

    // Cycles that must be ignored (R4).
    bus_cycle(16'hDE00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); read_four("R4");
    bus_cycle(16'hDF00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0); read_four("R4");
    bus_cycle(16'hDF00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0); read_four("R4");
    bus_cycle(16'h5F00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0); read_four("R4");

    // Data changing mid-strobe (R10).
    bus_cycle(16'hDF10, ID_A, 8'h00, 1'b0, 1'b0, 1'b1); read_four("R10");
    bus_cycle(16'hDF10, 8'h00, ID_A, 1'b0, 1'b0, 1'b1); read_four("R10");

    // Sweep every bank number; the masked instance shows mirrors (R8).
    for (int v = 0; v < 256; v++) begin
      bus_cycle({8'hDF, 8'(v)}, 8'(v), 8'(v), 1'b0, 1'b0, 1'b1);
      read_four("R8");
    end

    // Reset clears a set flag (R1).
    bus_cycle(16'hDF00, ID_A, ID_A, 1'b0, 1'b0, 1'b1);
    @(negedge clk); rst_n = 1'b0; exp_a = 1'b0; exp_b = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    read_four("R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule